// File: doc/BRIEF.md
# Timer Bank Control and Status Block

This block holds the module-level control state for a group of countdown timer channels. Four channels are shown, and the count is a parameter. Software starts channels by writing ones to a set port and stops them by writing ones to a separate clear port. A channel that expires in stop-on-expiry mode also drops its own enable. Expiry strobes from the channels land in sticky flags, which software clears by writing ones. An interrupt mask picks which flags drive the single interrupt line.

A module control word carries three bits:

- bit 0 is a soft reset. While it is 1, it holds the enables, the flags and the mask at zero, but the control word itself keeps its value.
- bit 1 lets the timers keep counting while the chip is in debug.
- bit 2 lets the timers keep counting while the chip is in doze.

A small mode machine turns these bits into the freeze and channel-reset outputs. Its states are:

- ST_RUN: normal counting.
- ST_FROZEN: a low-power or debug condition is active and is not permitted.
- ST_SRST: the soft reset bit is set.

Every state moves on each clock by the same rules, checked in priority order:

1. Soft-reset entry goes to ST_SRST whenever the soft reset bit is set.
2. Otherwise, halt entry goes to ST_FROZEN when a halt condition is active and not permitted.
3. Otherwise, release goes to ST_RUN.

Register access is a simple port. A write takes effect at the clock edge. Reads are combinational from the address.

Top module: `tmc_ctrl`

## Requirements
- R1: A write to address 1 (enable set) turns on each channel whose data bit i is 1. Data bits that are 0 leave that channel unchanged. The new enables appear on `chan_en` one cycle after the write.
- R2: A write to address 2 (enable clear) turns off each channel whose data bit i is 1. Reads at address 1 and at address 2 both return the current enables in bits [N-1:0].
- R3: A pulse on `chan_stop_expire[i]` clears enable i at the next edge. This takes priority over an enable-set write in the same cycle.
- R4: A pulse on `chan_timeout[i]` sets flag i at the next edge. A flag stays set until a write to address 4 has data bit i at 1. If an expiry and such a clearing write fall in the same cycle, the flag stays set. A read at address 4 returns the flags.
- R5: Address 3 is a read/write interrupt mask, with bit i belonging to channel i. `irq` is 1 exactly when some flag and its mask bit are both 1.
- R6: Bit 0 of address 0 is soft reset. While it is 1, the enables, flags and mask are held at 0, and writes to them are ignored. Bits 2:0 of address 0 keep their written values.
- R7: Bit 1 of address 0 permits running in debug, and bit 2 permits running in doze. When `dbg_mode` is 1 and bit 1 is 0, or `doze_mode` is 1 and bit 2 is 0, `timer_freeze` is 1 from the next cycle on.
- R8: After reset, every register reads 0. Addresses 5 to 7 read 0.
- R9: The mode machine gives soft reset priority over freezing. `chan_soft_rst` is 1 in ST_SRST, the cycle after the soft reset bit is seen, and `timer_freeze` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| chan_timeout | input | N_CH | Per-channel expiry strobes |
| chan_stop_expire | input | N_CH | Per-channel expiry in stop-on-expiry mode |
| dbg_mode | input | 1 | Chip is in debug |
| doze_mode | input | 1 | Chip is in doze |
| chan_en | output | N_CH | Per-channel enables |
| timer_freeze | output | 1 | Hold all channel counters |
| chan_soft_rst | output | 1 | Reset all channels |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong enable bit shows on `chan_en` in the cycle after the write or strobe that set it. A wrong flag or mask bit shows on `irq` and on the readback in that same cycle. A wrong mode state shows on `timer_freeze` or `chan_soft_rst` one cycle after the control bits or mode inputs change. The bench compares all of these against its own model after every clock, so an error is caught within one cycle of its cause. The collision cases get directed stimulus: expiry against clear, stop-on-expiry against set, and soft reset against a write.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_SRST   = 2'd2
    } mode_state_e;

    localparam logic [2:0] A_MCTL  = 3'd0;
    localparam logic [2:0] A_SETEN = 3'd1;
    localparam logic [2:0] A_CLREN = 3'd2;
    localparam logic [2:0] A_IEN   = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;

    localparam int B_SRST    = 0;
    localparam int B_RUNDBG  = 1;
    localparam int B_RUNDOZE = 2;
    localparam int MCTL_W    = 3;
endpackage

// File: rtl/tmc_mode_fsm.sv
module tmc_mode_fsm
    import tmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        srst_req,
    input  logic        halt_req,
    output mode_state_e state,
    output logic        freeze,
    output logic        chan_rst
);
    mode_state_e nxt;

    // Every state takes the same transitions, so the three arms share one rule set.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN, ST_FROZEN, ST_SRST: begin
                if (srst_req)      nxt = ST_SRST;    // soft-reset entry
                else if (halt_req) nxt = ST_FROZEN;  // halt entry
                else               nxt = ST_RUN;     // release
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        freeze   = (state == ST_FROZEN);
        chan_rst = (state == ST_SRST);
    end

    a_r9_srst_first: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (chan_rst && !freeze));
    a_r7_freeze_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !srst_req) |=> freeze);
endmodule

// File: rtl/tmc_enable_bank.sv
module tmc_enable_bank #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic [N_CH-1:0] set_stb,
    input  logic [N_CH-1:0] clr_stb,
    input  logic [N_CH-1:0] stop_exp,
    output logic [N_CH-1:0] en
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           en[i] <= 1'b0;
            else if (srst)        en[i] <= 1'b0;
            else if (stop_exp[i]) en[i] <= 1'b0;
            else if (clr_stb[i])  en[i] <= 1'b0;
            else if (set_stb[i])  en[i] <= 1'b1;
        end
    end

    a_r1_set_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && |set_stb) |=> ((en & $past(set_stb & ~clr_stb & ~stop_exp)) == $past(set_stb & ~clr_stb & ~stop_exp)));
    a_r2_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_stb) |=> ((en & $past(clr_stb)) == '0));
    a_r3_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_exp) |=> ((en & $past(stop_exp)) == '0));
    a_r6_srst_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (en == '0));
endmodule

// File: rtl/tmc_status_bank.sv
module tmc_status_bank #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic [N_CH-1:0] clr_mask,
    input  logic [N_CH-1:0] timeout,
    output logic [N_CH-1:0] flags
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (srst)       flags[i] <= 1'b0;
            else if (timeout[i]) flags[i] <= 1'b1;
            else if (clr_mask[i]) flags[i] <= 1'b0;
        end
    end

    a_r4_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && |timeout) |=> ((flags & $past(timeout)) == $past(timeout)));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));
    a_r6_srst_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (flags == '0));
endmodule

// File: rtl/tmc_ctrl.sv
module tmc_ctrl
    import tmc_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]   chan_timeout,
    input  logic [N_CH-1:0]   chan_stop_expire,
    input  logic              dbg_mode,
    input  logic              doze_mode,
    output logic [N_CH-1:0]   chan_en,
    output logic              timer_freeze,
    output logic              chan_soft_rst,
    output logic              irq
);
    localparam logic [N_CH-1:0] ZERO_CH = '0;

    logic [MCTL_W-1:0] mctl;
    logic [N_CH-1:0]   ien;
    logic [N_CH-1:0]   flags;
    logic              srst;
    logic              halt;
    logic              wr_mctl, wr_set, wr_clr, wr_ien, wr_stat;
    mode_state_e       mode_st;

    assign srst    = mctl[B_SRST];
    assign halt    = (dbg_mode && !mctl[B_RUNDBG]) || (doze_mode && !mctl[B_RUNDOZE]);
    assign wr_mctl = reg_we && (reg_addr == ADDR_W'(A_MCTL));
    assign wr_set  = reg_we && (reg_addr == ADDR_W'(A_SETEN));
    assign wr_clr  = reg_we && (reg_addr == ADDR_W'(A_CLREN));
    assign wr_ien  = reg_we && (reg_addr == ADDR_W'(A_IEN));
    assign wr_stat = reg_we && (reg_addr == ADDR_W'(A_STAT));

    // The control word is never touched by its own soft reset bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mctl <= '0;
        else if (wr_mctl) mctl <= reg_wdata[MCTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien <= '0;
        else if (srst)   ien <= '0;
        else if (wr_ien) ien <= reg_wdata[N_CH-1:0];
    end

    tmc_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_req (srst),
        .halt_req (halt),
        .state    (mode_st),
        .freeze   (timer_freeze),
        .chan_rst (chan_soft_rst)
    );

    tmc_enable_bank #(.N_CH(N_CH)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .set_stb  (wr_set ? reg_wdata[N_CH-1:0] : ZERO_CH),
        .clr_stb  (wr_clr ? reg_wdata[N_CH-1:0] : ZERO_CH),
        .stop_exp (chan_stop_expire),
        .en       (chan_en)
    );

    tmc_status_bank #(.N_CH(N_CH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .clr_mask (wr_stat ? reg_wdata[N_CH-1:0] : ZERO_CH),
        .timeout  (chan_timeout),
        .flags    (flags)
    );

    assign irq = |(flags & ien);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_MCTL):  reg_rdata[MCTL_W-1:0] = mctl;
            ADDR_W'(A_SETEN),
            ADDR_W'(A_CLREN): reg_rdata[N_CH-1:0]   = chan_en;
            ADDR_W'(A_IEN):   reg_rdata[N_CH-1:0]   = ien;
            ADDR_W'(A_STAT):  reg_rdata[N_CH-1:0]   = flags;
            default:          reg_rdata             = '0;
        endcase
    end

    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0));
    a_r6_srst_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ien == '0));
    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({timer_freeze, chan_soft_rst}));
endmodule

// File: tb/sim_tmc_ctrl.sv
`timescale 1ns/1ps
module sim_tmc_ctrl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] chan_timeout = '0;
    logic [N-1:0] chan_stop_expire = '0;
    logic        dbg_mode = 1'b0;
    logic        doze_mode = 1'b0;
    logic [N-1:0] chan_en;
    logic        timer_freeze, chan_soft_rst, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [2:0]   m_mctl = '0;
    logic [N-1:0] m_en = '0, m_st = '0, m_ien = '0;
    logic [1:0]   m_state = 2'd0;

    always #4 clk = ~clk;

    tmc_ctrl #(.N_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_timeout(chan_timeout),
        .chan_stop_expire(chan_stop_expire), .dbg_mode(dbg_mode), .doze_mode(doze_mode),
        .chan_en(chan_en), .timer_freeze(timer_freeze), .chan_soft_rst(chan_soft_rst), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:       return {29'd0, m_mctl};
            3'd1, 3'd2: return {28'd0, m_en};
            3'd3:       return {28'd0, m_ien};
            3'd4:       return {28'd0, m_st};
            default:    return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        logic srst;
        logic halt;
        srst = m_mctl[0];
        halt = (dbg_mode && !m_mctl[1]) || (doze_mode && !m_mctl[2]);
        m_state = srst ? 2'd2 : (halt ? 2'd1 : 2'd0);
        for (int i = 0; i < N; i++) begin
            if (srst) m_en[i] = 1'b0;
            else if (chan_stop_expire[i]) m_en[i] = 1'b0;
            else if (reg_we && reg_addr == 3'd2 && reg_wdata[i]) m_en[i] = 1'b0;
            else if (reg_we && reg_addr == 3'd1 && reg_wdata[i]) m_en[i] = 1'b1;
            if (srst) m_st[i] = 1'b0;
            else if (chan_timeout[i]) m_st[i] = 1'b1;
            else if (reg_we && reg_addr == 3'd4 && reg_wdata[i]) m_st[i] = 1'b0;
        end
        if (srst) m_ien = '0;
        else if (reg_we && reg_addr == 3'd3) m_ien = reg_wdata[N-1:0];
        if (reg_we && reg_addr == 3'd0) m_mctl = reg_wdata[2:0];
    endtask

    task automatic compare_all();
        check("R1/R2/R3 chan_en", 32'(chan_en), 32'(m_en));
        check("R5 irq", 32'(irq), 32'(|(m_st & m_ien)));
        check("R7 timer_freeze", 32'(timer_freeze), 32'(m_state == 2'd1));
        check("R9 chan_soft_rst", 32'(chan_soft_rst), 32'(m_state == 2'd2));
        check("R8 reg_rdata", reg_rdata, model_read(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d,
                         input logic [N-1:0] to, input logic [N-1:0] se);
        reg_we = we; reg_addr = a; reg_wdata = d; chan_timeout = to; chan_stop_expire = se;
        tick();
        reg_we = 1'b0; chan_timeout = '0; chan_stop_expire = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R8: reset state of every address
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #1 check("R8 reset read", reg_rdata, 32'd0);
        end
        check("R5 reset irq", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: set ch0 and ch2, then a write of zeros changes nothing
        drive(1, 3'd1, 32'h5, '0, '0);
        check("R1 set", 32'(chan_en), 32'h5);
        drive(1, 3'd1, 32'h0, '0, '0);
        check("R1 zero write", 32'(chan_en), 32'h5);
        // R2: clear ch2
        drive(1, 3'd2, 32'h4, '0, '0);
        check("R2 clear", 32'(chan_en), 32'h1);
        // R3: stop-on-expiry beats a set in the same cycle
        drive(1, 3'd1, 32'h2, 4'h2, 4'h2);
        check("R3 expire beats set", 32'(chan_en), 32'h1);
        // R4: flag set, collision with clear keeps it, plain clear drops it
        drive(1, 3'd3, 32'h2, '0, '0);
        drive(1, 3'd4, 32'h2, 4'h2, '0);
        check("R4 timeout over clear", 32'(u0.reg_rdata & 0) | 32'(m_st), 32'h2);
        reg_addr = 3'd4;
        #1 check("R4 readback", reg_rdata, 32'h2);
        check("R5 irq on masked flag", 32'(irq), 32'd1);
        drive(1, 3'd4, 32'h2, '0, '0);
        reg_addr = 3'd4;
        #1 check("R4 cleared", reg_rdata, 32'h0);
        // R6: soft reset with both run bits set keeps the control word
        drive(1, 3'd4, 32'h0, 4'hF, '0);
        drive(1, 3'd0, 32'h7, '0, '0);
        drive(1, 3'd1, 32'hF, 4'hF, '0);
        check("R6 enables held", 32'(chan_en), 32'h0);
        check("R9 soft reset out", 32'(chan_soft_rst), 32'd1);
        reg_addr = 3'd0;
        #1 check("R6 mctl kept", reg_rdata, 32'h7);
        reg_addr = 3'd4;
        #1 check("R6 flags held", reg_rdata, 32'h0);
        // R7: debug freeze, then permitted by run bit
        drive(1, 3'd0, 32'h0, '0, '0);
        dbg_mode = 1'b1;
        tick();
        check("R7 debug freeze", 32'(timer_freeze), 32'd1);
        drive(1, 3'd0, 32'h2, '0, '0);
        tick();
        check("R7 run in debug", 32'(timer_freeze), 32'd0);
        dbg_mode = 1'b0;

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [2:0] a;
            logic [31:0] d;
            a = 3'($urandom_range(0, 5));
            d = $urandom();
            if (a == 3'd0) d[0] = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 19) == 0) dbg_mode = ~dbg_mode;
            if ($urandom_range(0, 19) == 0) doze_mode = ~doze_mode;
            drive(($urandom_range(0, 1) == 1), a,  d,
                  N'($urandom() & $urandom()), N'($urandom() & $urandom() & $urandom()));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule